// File: doc/BRIEF.md
# Standby Entry and Wakeup Controller

This block moves a core into a deep low-power standby state and brings it back out. Software sets a standby-enable bit and then issues a sleep request strobe. If the bit is set, the block drops the core clock enable, clears the timer-start register and shows the standby code on a two-bit status output. If the bit is clear, the strobe is an ordinary sleep and this block does nothing. While in standby, an eligible interrupt starts an 8-bit settling counter. Software preloads this counter so the oscillator has time to settle. The counter counts up on a prescaled tick. When it wraps from 0xFF to 0x00, the clock enable comes back and a one-cycle wakeup pulse is issued, together with the level of the interrupt that won.

After wakeup the counter keeps running for as long as the standby-enable bit stays set. If software clears the bit, the counter freezes and the block returns to run mode. If the bit is never cleared, the next wrap of the counter puts the block back into standby. This gives an automatic fallback when the supply is unstable and the wakeup handler fails to run.

The controller has four states. `ST_RUN` is normal operation. `ST_STBY` is standby with clocks stopped. `ST_SETTLE` means clocks are still stopped while the counter runs out. `ST_AWAKE` means clocks are back on and the counter is still armed. The transitions are:
- RUN→STBY on a sleep strobe with the enable bit set.
- STBY→SETTLE on an eligible wakeup source.
- SETTLE→AWAKE on counter wrap.
- AWAKE→RUN when the enable bit is clear.
- AWAKE→STBY on counter wrap, or on a new sleep strobe, while the enable bit is set.

Top module: `stby_ctrl`

## Requirements
- R1: A sleep strobe sampled in run mode enters standby only when the enable bit (address 0, bit 0) is 1; with the bit at 0 the status stays 00 and the clock enable stays 1. A sleep strobe during standby or settling changes nothing.
- R2: The status output is `{status[1],status[0]}` = 01 while clocks are stopped (standby and settling) and 00 otherwise; status[1] is never 1.
- R3: In standby, NMI always wakes the block. An IRQ request or a peripheral request wakes it only when its 4-bit level is strictly greater than the 4-bit mask level. A peripheral request flagged as coming from the interval timer never wakes it.
- R4: The reported wake level is 15 for NMI. Otherwise it is the larger level of the eligible IRQ and peripheral requests, and a tie goes to IRQ. The level holds until the next wakeup.
- R5: After the wakeup source is sampled at edge E0, the clock enable returns after edge E0 + (256 − P)·2^(n+1). Here P is the counter preset (address 2) and n is the divider select (address 1, bits 2:0). The exit happens on the 0xFF→0x00 wrap.
- R6: `wake_pulse` is high for exactly one cycle, in the first cycle in which `core_clk_en` is 1 again.
- R7: Entering standby clears the timer-start register (address 3) to 0x00. The enable bit and the full control/status byte at address 1 keep their values.
- R8: If software clears the enable bit after wakeup, the block returns to run mode and the counter value freezes. No re-entry follows.
- R9: If the enable bit stays set after wakeup, the counter keeps running from 0x00. Standby is re-entered 256·2^(n+1) cycles after the wakeup exit.
- R10: Reset (asynchronous, active low) forces clock enable 1, status 00 and wake pulse 0, and clears all four registers to 0x00.
- R11: Register writes take effect at the clock edge where `reg_we` is 1. Reads are combinational on `reg_addr`, and address 2 returns the live counter.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-running control clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for `reg_addr` |
| sleep_req | input | 1 | Sleep request strobe |
| nmi_req | input | 1 | Non-maskable wakeup request |
| irq_req | input | 1 | External interrupt request |
| irq_lvl | input | 4 | External request level |
| per_req | input | 1 | Peripheral interrupt request |
| per_from_itimer | input | 1 | Peripheral request comes from the interval timer |
| per_lvl | input | 4 | Peripheral request level |
| mask_lvl | input | 4 | Current interrupt mask level |
| core_clk_en | output | 1 | Core clock enable |
| status | output | 2 | Mode code: 01 standby, 00 otherwise |
| wake_pulse | output | 1 | One-cycle wakeup interrupt strobe |
| wake_lvl | output | 4 | Level of the winning wakeup source |

## Verification
The bench sweeps every pair of request level and mask level. A design whose comparison uses greater-or-equal would wake on equal levels, and a design whose comparison is inverted would wake on levels below the mask. Settling time is measured for several presets and every low divider select. An off-by-one in the prescaler or the wrap detect shows up as an exit one tick early or late. The bench also checks the interval-timer exclusion and the re-entry after a full counter period with the enable bit left set. A controller that never re-arms would stay awake, and one that keeps the counter running after the bit is cleared would drop back into standby.

// File: rtl/stby_pkg.sv
package stby_pkg;

    typedef enum logic [1:0] {
        ST_RUN    = 2'd0,
        ST_STBY   = 2'd1,
        ST_SETTLE = 2'd2,
        ST_AWAKE  = 2'd3
    } stby_state_e;

    // register addresses
    localparam int unsigned REG_CTRL   = 0;
    localparam int unsigned REG_CSR    = 1;
    localparam int unsigned REG_CNT    = 2;
    localparam int unsigned REG_TSTART = 3;

    // status output codes
    localparam logic [1:0] STAT_RUN  = 2'b00;
    localparam logic [1:0] STAT_STBY = 2'b01;

endpackage

// File: rtl/stby_regs.sv
module stby_regs
    import stby_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int ADDR_W = 2,
    parameter int CNT_W  = 8,
    parameter int DIV_W  = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    input  logic              tstart_clr,
    input  logic [CNT_W-1:0]  cnt_val,
    output logic [DATA_W-1:0] rdata,
    output logic              stby_en,
    output logic [DIV_W-1:0]  div_sel,
    output logic              cnt_load,
    output logic [CNT_W-1:0]  cnt_load_val,
    output logic [DATA_W-1:0] tstart_val
);

    logic              en_q;
    logic [DATA_W-1:0] csr_q;
    logic [DATA_W-1:0] tstart_q;

    logic hit_ctrl, hit_csr, hit_cnt, hit_tstart;

    always_comb begin
        hit_ctrl   = we && (addr == ADDR_W'(REG_CTRL));
        hit_csr    = we && (addr == ADDR_W'(REG_CSR));
        hit_cnt    = we && (addr == ADDR_W'(REG_CNT));
        hit_tstart = we && (addr == ADDR_W'(REG_TSTART));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            en_q <= 1'b0;
        end else if (hit_ctrl) begin
            en_q <= wdata[0];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            csr_q <= '0;
        end else if (hit_csr) begin
            csr_q <= wdata;
        end
    end

    // entry into standby wins over a same-cycle write
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tstart_q <= '0;
        end else if (tstart_clr) begin
            tstart_q <= '0;
        end else if (hit_tstart) begin
            tstart_q <= wdata;
        end
    end

    always_comb begin
        unique case (int'(addr))
            REG_CTRL:   rdata = DATA_W'(en_q);
            REG_CSR:    rdata = csr_q;
            REG_CNT:    rdata = DATA_W'(cnt_val);
            REG_TSTART: rdata = tstart_q;
            default:    rdata = '0;
        endcase
    end

    assign stby_en      = en_q;
    assign div_sel      = csr_q[DIV_W-1:0];
    assign cnt_load     = hit_cnt;
    assign cnt_load_val = wdata[CNT_W-1:0];
    assign tstart_val   = tstart_q;

endmodule

// File: rtl/stby_settle_timer.sv
module stby_settle_timer #(
    parameter int CNT_W = 8,
    parameter int DIV_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             pre_clr,
    input  logic [DIV_W-1:0] div_sel,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic [CNT_W-1:0] cnt,
    output logic             ovf
);

    localparam int PRE_W = 1 << DIV_W;

    logic [PRE_W-1:0] pre_q;
    logic [PRE_W-1:0] div_mask;
    logic [CNT_W-1:0] cnt_q;
    logic             tick;

    // prescaler bits that must all be one for a tick: 0..div_sel
    for (genvar g = 0; g < PRE_W; g++) begin : g_mask
        assign div_mask[g] = (DIV_W'(g) <= div_sel);
    end

    always_comb begin
        tick = run && (&(pre_q | ~div_mask));
        ovf  = tick && (&cnt_q);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pre_q <= '0;
        end else if (pre_clr) begin
            pre_q <= '0;
        end else if (run) begin
            pre_q <= pre_q + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= load_val;
        end else if (tick) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign cnt = cnt_q;

endmodule

// File: rtl/stby_wake_arb.sv
module stby_wake_arb #(
    parameter int LVL_W = 4
) (
    input  logic             nmi_req,
    input  logic             irq_req,
    input  logic [LVL_W-1:0] irq_lvl,
    input  logic             per_req,
    input  logic             per_from_itimer,
    input  logic [LVL_W-1:0] per_lvl,
    input  logic [LVL_W-1:0] mask_lvl,
    output logic             wake_ok,
    output logic [LVL_W-1:0] win_lvl
);

    logic irq_ok;
    logic per_ok;

    always_comb begin
        irq_ok  = irq_req && (irq_lvl > mask_lvl);
        per_ok  = per_req && !per_from_itimer && (per_lvl > mask_lvl);
        wake_ok = nmi_req || irq_ok || per_ok;

        if (nmi_req) begin
            win_lvl = '1;
        end else if (irq_ok && per_ok) begin
            win_lvl = (per_lvl > irq_lvl) ? per_lvl : irq_lvl;
        end else if (per_ok) begin
            win_lvl = per_lvl;
        end else begin
            win_lvl = irq_lvl;
        end
    end

endmodule

// File: rtl/stby_fsm.sv
module stby_fsm
    import stby_pkg::*;
#(
    parameter int LVL_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sleep_req,
    input  logic             stby_en,
    input  logic             wake_ok,
    input  logic [LVL_W-1:0] win_lvl,
    input  logic             ovf,
    output stby_state_e      state,
    output logic             core_clk_en,
    output logic [1:0]       status,
    output logic             wake_pulse,
    output logic [LVL_W-1:0] wake_lvl,
    output logic             tstart_clr,
    output logic             timer_run,
    output logic             pre_clr
);

    stby_state_e st_q, st_d;
    logic             pulse_q;
    logic [LVL_W-1:0] lvl_q;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= ST_RUN;
        end else begin
            st_q <= st_d;
        end
    end

    // transitions
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ST_RUN: begin
                if (sleep_req && stby_en) st_d = ST_STBY;
            end
            ST_STBY: begin
                if (wake_ok) st_d = ST_SETTLE;
            end
            ST_SETTLE: begin
                if (ovf) st_d = ST_AWAKE;
            end
            ST_AWAKE: begin
                if (!stby_en)              st_d = ST_RUN;
                else if (ovf || sleep_req) st_d = ST_STBY;
            end
            default: st_d = ST_RUN;
        endcase
    end

    // outputs
    always_comb begin
        tstart_clr = (st_d == ST_STBY) && (st_q != ST_STBY);
        pre_clr    = (st_q == ST_STBY) && wake_ok;
        timer_run  = (st_q == ST_SETTLE) || ((st_q == ST_AWAKE) && stby_en);
        unique case (st_q)
            ST_RUN: begin
                core_clk_en = 1'b1;
                status      = STAT_RUN;
            end
            ST_STBY, ST_SETTLE: begin
                core_clk_en = 1'b0;
                status      = STAT_STBY;
            end
            ST_AWAKE: begin
                core_clk_en = 1'b1;
                status      = STAT_RUN;
            end
            default: begin
                core_clk_en = 1'b1;
                status      = STAT_RUN;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pulse_q <= 1'b0;
            lvl_q   <= '0;
        end else begin
            pulse_q <= (st_q == ST_SETTLE) && ovf;
            if (pre_clr) lvl_q <= win_lvl;
        end
    end

    assign state      = st_q;
    assign wake_pulse = pulse_q;
    assign wake_lvl   = lvl_q;

endmodule

// File: rtl/stby_ctrl.sv
module stby_ctrl
    import stby_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int ADDR_W = 2,
    parameter int CNT_W  = 8,
    parameter int DIV_W  = 3,
    parameter int LVL_W  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_we,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    input  logic              sleep_req,
    input  logic              nmi_req,
    input  logic              irq_req,
    input  logic [LVL_W-1:0]  irq_lvl,
    input  logic              per_req,
    input  logic              per_from_itimer,
    input  logic [LVL_W-1:0]  per_lvl,
    input  logic [LVL_W-1:0]  mask_lvl,
    output logic              core_clk_en,
    output logic [1:0]        status,
    output logic              wake_pulse,
    output logic [LVL_W-1:0]  wake_lvl
);

    stby_state_e       st;
    logic              stby_en;
    logic [DIV_W-1:0]  div_sel;
    logic              cnt_load;
    logic [CNT_W-1:0]  cnt_load_val;
    logic [CNT_W-1:0]  cnt_val;
    logic [DATA_W-1:0] tstart_val;
    logic              ovf;
    logic              wake_ok;
    logic [LVL_W-1:0]  win_lvl;
    logic              tstart_clr;
    logic              timer_run;
    logic              pre_clr;

    stby_regs #(
        .DATA_W(DATA_W), .ADDR_W(ADDR_W), .CNT_W(CNT_W), .DIV_W(DIV_W)
    ) u_regs (
        .clk          (clk),
        .rst_n        (rst_n),
        .we           (reg_we),
        .addr         (reg_addr),
        .wdata        (reg_wdata),
        .tstart_clr   (tstart_clr),
        .cnt_val      (cnt_val),
        .rdata        (reg_rdata),
        .stby_en      (stby_en),
        .div_sel      (div_sel),
        .cnt_load     (cnt_load),
        .cnt_load_val (cnt_load_val),
        .tstart_val   (tstart_val)
    );

    stby_settle_timer #(
        .CNT_W(CNT_W), .DIV_W(DIV_W)
    ) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .run      (timer_run),
        .pre_clr  (pre_clr),
        .div_sel  (div_sel),
        .load     (cnt_load),
        .load_val (cnt_load_val),
        .cnt      (cnt_val),
        .ovf      (ovf)
    );

    stby_wake_arb #(
        .LVL_W(LVL_W)
    ) u_arb (
        .nmi_req         (nmi_req),
        .irq_req         (irq_req),
        .irq_lvl         (irq_lvl),
        .per_req         (per_req),
        .per_from_itimer (per_from_itimer),
        .per_lvl         (per_lvl),
        .mask_lvl        (mask_lvl),
        .wake_ok         (wake_ok),
        .win_lvl         (win_lvl)
    );

    stby_fsm #(
        .LVL_W(LVL_W)
    ) u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .sleep_req   (sleep_req),
        .stby_en     (stby_en),
        .wake_ok     (wake_ok),
        .win_lvl     (win_lvl),
        .ovf         (ovf),
        .state       (st),
        .core_clk_en (core_clk_en),
        .status      (status),
        .wake_pulse  (wake_pulse),
        .wake_lvl    (wake_lvl),
        .tstart_clr  (tstart_clr),
        .timer_run   (timer_run),
        .pre_clr     (pre_clr)
    );

endmodule

// File: rtl/stby_ctrl_chk.sv
module stby_ctrl_chk
    import stby_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int CNT_W  = 8,
    parameter int LVL_W  = 4
) (
    input logic              clk,
    input logic              rst_n,
    input stby_state_e       st,
    input logic              stby_en,
    input logic [DATA_W-1:0] tstart_val,
    input logic [CNT_W-1:0]  cnt_val,
    input logic [1:0]        status,
    input logic              core_clk_en,
    input logic              wake_pulse,
    input logic              nmi_req,
    input logic              irq_req,
    input logic [LVL_W-1:0]  irq_lvl,
    input logic              per_req,
    input logic              per_from_itimer,
    input logic [LVL_W-1:0]  per_lvl,
    input logic [LVL_W-1:0]  mask_lvl
);

    assert_entry_gated_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(status[0]) |-> $past(stby_en));

    assert_status_legal_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !status[1]);

    assert_wake_source_R3: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(st) == ST_STBY && st == ST_SETTLE) |->
        $past(nmi_req || (irq_req && irq_lvl > mask_lvl)
              || (per_req && !per_from_itimer && per_lvl > mask_lvl)));

    assert_exit_on_wrap_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(st) == ST_SETTLE && st == ST_AWAKE) |-> (cnt_val == '0));

    assert_pulse_with_clock_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(core_clk_en) |-> wake_pulse);

    assert_pulse_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
        wake_pulse |=> !wake_pulse);

    assert_tstart_cleared_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(status[0]) |-> (tstart_val == '0));

    assert_return_run_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_AWAKE && !stby_en) |=> (st == ST_RUN));

    assert_reenter_armed_R9: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(st) == ST_AWAKE && st == ST_STBY) |-> $past(stby_en));

endmodule

bind stby_ctrl stby_ctrl_chk #(
    .DATA_W(DATA_W), .CNT_W(CNT_W), .LVL_W(LVL_W)
) u_chk (
    .clk             (clk),
    .rst_n           (rst_n),
    .st              (st),
    .stby_en         (stby_en),
    .tstart_val      (tstart_val),
    .cnt_val         (cnt_val),
    .status          (status),
    .core_clk_en     (core_clk_en),
    .wake_pulse      (wake_pulse),
    .nmi_req         (nmi_req),
    .irq_req         (irq_req),
    .irq_lvl         (irq_lvl),
    .per_req         (per_req),
    .per_from_itimer (per_from_itimer),
    .per_lvl         (per_lvl),
    .mask_lvl        (mask_lvl)
);

// File: tb/stby_ctrl_tb.sv
module stby_ctrl_tb;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       reg_we = 1'b0;
    logic [1:0] reg_addr = '0;
    logic [7:0] reg_wdata = '0;
    logic [7:0] reg_rdata;
    logic       sleep_req = 1'b0;
    logic       nmi_req = 1'b0;
    logic       irq_req = 1'b0;
    logic [3:0] irq_lvl = '0;
    logic       per_req = 1'b0;
    logic       per_from_itimer = 1'b0;
    logic [3:0] per_lvl = '0;
    logic [3:0] mask_lvl = '0;
    logic       core_clk_en;
    logic [1:0] status;
    logic       wake_pulse;
    logic [3:0] wake_lvl;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    stby_ctrl u_dut (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .sleep_req(sleep_req),
        .nmi_req(nmi_req), .irq_req(irq_req), .irq_lvl(irq_lvl),
        .per_req(per_req), .per_from_itimer(per_from_itimer), .per_lvl(per_lvl),
        .mask_lvl(mask_lvl), .core_clk_en(core_clk_en), .status(status),
        .wake_pulse(wake_pulse), .wake_lvl(wake_lvl)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wr(input int a, input int d);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = 2'(a); reg_wdata = 8'(d);
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic rd(input int a, output int d);
        reg_addr = 2'(a);
        #1;
        d = int'(reg_rdata);
    endtask

    task automatic pulse_sleep();
        @(negedge clk);
        sleep_req = 1'b1;
        @(negedge clk);
        sleep_req = 1'b0;
    endtask

    // counts posedges until the clock enable is seen high; -1 after cap
    task automatic wait_exit(input int cap, output int n);
        n = -1;
        for (int i = 1; i <= cap; i++) begin
            @(posedge clk);
            @(negedge clk);
            if (core_clk_en) begin
                n = i;
                break;
            end
        end
    endtask

    task automatic enter_stby(input int p, input int sel);
        wr(2, p);
        wr(1, sel);
        wr(0, 1);
        pulse_sleep();
    endtask

    initial begin
        #(8 * 200000);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        int v, n, c1, c2;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        // R10 reset state
        chk(core_clk_en == 1'b1, "R10 clk_en", int'(core_clk_en), 1);
        chk(status == 2'b00, "R10 status", int'(status), 0);
        chk(wake_pulse == 1'b0, "R10 pulse", int'(wake_pulse), 0);
        for (int a = 0; a < 4; a++) begin
            rd(a, v);
            chk(v == 0, "R10 reg", v, 0);
        end

        // R1 ordinary sleep with enable clear
        wr(0, 0);
        pulse_sleep();
        chk(status == 2'b00, "R1 no standby status", int'(status), 0);
        @(negedge clk);
        chk(core_clk_en == 1'b1, "R1 no standby clk", int'(core_clk_en), 1);

        // R7, R11 retention and clear on entry
        wr(3, 8'hA5);
        rd(3, v);
        chk(v == 8'hA5, "R11 tstart write", v, 8'hA5);
        wr(1, 8'h83);
        wr(2, 8'hFE);
        rd(2, v);
        chk(v == 8'hFE, "R11 cnt write", v, 8'hFE);
        wr(0, 1);
        pulse_sleep();
        chk(status == 2'b01, "R2 standby status", int'(status), 1);
        chk(core_clk_en == 1'b0, "R1 standby clk", int'(core_clk_en), 0);
        rd(3, v);
        chk(v == 0, "R7 tstart cleared", v, 0);
        rd(1, v);
        chk(v == 8'h83, "R7 csr kept", v, 8'h83);
        rd(0, v);
        chk(v == 1, "R7 enable kept", v, 1);
        pulse_sleep();
        chk(status == 2'b01, "R1 sleep ignored in standby", int'(status), 1);

        // R3 interval timer never wakes
        mask_lvl = 4'd0; per_lvl = 4'd15; per_from_itimer = 1'b1;
        @(negedge clk);
        per_req = 1'b1;
        wait_exit(12, n);
        chk(n == -1, "R3 itimer excluded", n, -1);
        per_from_itimer = 1'b0;
        wait_exit(100, n);
        chk(n == 1 + 2 * 16, "R5 settle P=FE n=3", n, 33);
        chk(wake_lvl == 4'd15, "R4 periph level", int'(wake_lvl), 15);
        chk(wake_pulse == 1'b1, "R6 pulse on exit", int'(wake_pulse), 1);
        per_req = 1'b0;
        @(negedge clk);
        chk(wake_pulse == 1'b0, "R6 pulse single", int'(wake_pulse), 0);
        chk(core_clk_en == 1'b1 && status == 2'b00, "R2 awake status", int'(status), 0);
        wr(0, 0);

        // R5 settling time sweep
        for (int sel = 0; sel < 4; sel++) begin
            for (int k = 0; k < 3; k++) begin
                int p, exp;
                p = (k == 0) ? 8'hFF : ((k == 1) ? 8'hF0 : 8'hC0);
                exp = 1 + (256 - p) * (1 << (sel + 1));
                enter_stby(p, sel);
                nmi_req = 1'b1;
                wait_exit(2000, n);
                nmi_req = 1'b0;
                chk(n == exp, "R5 settle time", n, exp);
                wr(0, 0);
            end
        end

        // R3, R4 level versus mask sweep on the IRQ input
        for (int m = 0; m < 16; m++) begin
            for (int l = 0; l < 16; l++) begin
                enter_stby(8'hFF, 0);
                mask_lvl = 4'(m); irq_lvl = 4'(l); irq_req = 1'b1;
                wait_exit(8, n);
                irq_req = 1'b0;
                if (l > m) begin
                    chk(n == 3, "R3 irq above mask wakes", n, 3);
                    chk(wake_lvl == 4'(l), "R4 irq level", int'(wake_lvl), l);
                end else begin
                    chk(n == -1, "R3 irq not above mask stays", n, -1);
                    nmi_req = 1'b1;
                    wait_exit(8, n);
                    nmi_req = 1'b0;
                end
                wr(0, 0);
            end
        end

        // R3 peripheral versus mask
        for (int l = 0; l < 16; l++) begin
            enter_stby(8'hFF, 0);
            mask_lvl = 4'd7; per_lvl = 4'(l); per_req = 1'b1;
            wait_exit(8, n);
            per_req = 1'b0;
            if (l > 7) chk(n == 3, "R3 periph wakes", n, 3);
            else begin
                chk(n == -1, "R3 periph stays", n, -1);
                nmi_req = 1'b1;
                wait_exit(8, n);
                nmi_req = 1'b0;
            end
            wr(0, 0);
        end

        // R4 priority
        enter_stby(8'hFF, 0);
        mask_lvl = 4'd3; irq_lvl = 4'd5; per_lvl = 4'd9;
        irq_req = 1'b1; per_req = 1'b1;
        wait_exit(8, n);
        irq_req = 1'b0; per_req = 1'b0;
        chk(wake_lvl == 4'd9, "R4 higher level wins", int'(wake_lvl), 9);
        wr(0, 0);
        enter_stby(8'hFF, 0);
        irq_lvl = 4'd11; per_lvl = 4'd6;
        irq_req = 1'b1; per_req = 1'b1;
        wait_exit(8, n);
        irq_req = 1'b0; per_req = 1'b0;
        chk(wake_lvl == 4'd11, "R4 irq higher wins", int'(wake_lvl), 11);
        wr(0, 0);
        enter_stby(8'hFF, 0);
        irq_lvl = 4'd5; irq_req = 1'b1; nmi_req = 1'b1;
        wait_exit(8, n);
        irq_req = 1'b0; nmi_req = 1'b0;
        chk(wake_lvl == 4'd15, "R4 nmi wins", int'(wake_lvl), 15);
        wr(0, 0);

        // R9 re-entry with enable left set, divider 2
        enter_stby(8'hFF, 0);
        nmi_req = 1'b1;
        wait_exit(8, n);
        nmi_req = 1'b0;
        chk(n == 3, "R5 short settle", n, 3);
        wr(3, 8'h5A);
        n = 2;
        for (int i = 0; i < 2000; i++) begin
            if (status == 2'b01) break;
            @(posedge clk);
            @(negedge clk);
            n++;
        end
        chk(n == 512, "R9 re-entry period", n, 512);
        chk(core_clk_en == 1'b0, "R9 clocks off again", int'(core_clk_en), 0);
        rd(3, v);
        chk(v == 0, "R7 tstart cleared on re-entry", v, 0);
        nmi_req = 1'b1;
        wait_exit(2000, n);
        nmi_req = 1'b0;
        chk(n == 513, "R9 settle from zero", n, 513);

        // R8 clearing the enable stops the counter
        wr(0, 0);
        @(negedge clk);
        rd(2, c1);
        repeat (20) @(negedge clk);
        rd(2, c2);
        chk(c1 == c2, "R8 counter frozen", c2, c1);
        repeat (600) @(negedge clk);
        chk(status == 2'b00 && core_clk_en, "R8 no re-entry", int'(status), 0);

        // R10 reset during settling
        enter_stby(8'h00, 2);
        nmi_req = 1'b1;
        repeat (10) @(negedge clk);
        chk(status == 2'b01, "R5 still settling", int'(status), 1);
        rst_n = 1'b0;
        #1;
        chk(core_clk_en == 1'b1, "R10 async clk_en", int'(core_clk_en), 1);
        chk(status == 2'b00, "R10 async status", int'(status), 0);
        nmi_req = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        for (int a = 0; a < 4; a++) begin
            rd(a, v);
            chk(v == 0, "R10 reg after reset", v, 0);
        end

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule